// File: doc/BRIEF.md
# Advanced Load Address Table

This block keeps a small associative record of loads that a compiler has moved above stores that might alias them. Each early load writes an entry that holds its destination register number and the 8-byte memory granule it read. Every store address in the pipeline is snooped against all entries, and a store that overlaps a recorded granule removes that entry. A later check names the destination register. If a valid entry for that register survives, the early value is still good. If no entry survives, the pipeline must either quietly re-issue the load or jump to recovery code, depending on the form of the check.

A check may also ask for its entry to be dropped once the lookup is done. An early load that was also speculative, and that had to hold back a fault, creates no entry. It reports the destination register so that the register can be marked as holding a deferred exception. The table has a fixed number of slots. A load to a register that is already tracked reuses that register's slot. When every slot is taken, a rotating pointer picks the slot to replace.

Top module: `alat_table`

## Requirements
- R1: After reset every slot is empty and all outputs are low, so the first check of any register misses.
- R2: An insert with `ins_defer_i`=0 records its register and granule, and a later check of that register hits. Every check result appears on the `res_*` outputs one clock after the check is presented, with `res_valid_o`=1.
- R3: On a hit, `res_hit_o`=1 and both `res_reload_o` and `res_recover_o` are 0.
- R4: A miss by a check with `chk_mode_i`=0 (reload form) gives `res_reload_o`=1 and `res_recover_o`=0.
- R5: A miss by a check with `chk_mode_i`=1 (branch form) gives `res_recover_o`=1 and `res_reload_o`=0.
- R6: When neither access is wide, a store conflicts with an entry if address bits [ADDR_W-1:3] are equal, and the conflict invalidates that entry. A store to a different granule leaves the entry valid.
- R7: When either the entry or the store is wide (16 bytes, `*_wide_i`=1), only address bits [ADDR_W-1:4] are compared.
- R8: A check with `chk_clear_i`=1 still reports its own lookup but removes the matching entry, so the next check of that register misses. Without the clear, the entry stays.
- R9: An insert to a register that is already tracked overwrites that slot. The old granule no longer matters, and the register never has more than one valid slot.
- R10: An insert with `ins_defer_i`=1 allocates nothing and removes any existing entry for its register. One clock later it pulses `nat_set_o` with `nat_reg_o` equal to that register.
- R11: An insert that needs a new slot takes the lowest-numbered free slot. When every slot is full, it replaces the slot named by a rotating pointer. The pointer starts at slot 0 after reset and advances by one after each replacement.
- R12: If an insert and a store to the same granule arrive in the same cycle, the store counts as older and the new entry stays valid.
- R13: A check looks at the table as it stood before the cycle's own store, clear and insert. A store in the same cycle does not turn the check into a miss, and an insert in the same cycle does not turn it into a hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ins_valid_i | input | 1 | Early load writes the table this cycle |
| ins_reg_i | input | REG_W | Destination register of the early load |
| ins_addr_i | input | ADDR_W | Byte address of the early load |
| ins_wide_i | input | 1 | Early load is 16 bytes wide |
| ins_defer_i | input | 1 | Early load deferred a fault and must not allocate |
| st_valid_i | input | 1 | Store address is present |
| st_addr_i | input | ADDR_W | Store byte address |
| st_wide_i | input | 1 | Store is 16 bytes wide |
| chk_valid_i | input | 1 | Check is presented |
| chk_reg_i | input | REG_W | Register being checked |
| chk_mode_i | input | 1 | 0 = reload form, 1 = branch-to-recovery form |
| chk_clear_i | input | 1 | Remove the matching entry after the lookup |
| res_valid_o | output | 1 | Check result is valid |
| res_hit_o | output | 1 | Entry was found |
| res_reload_o | output | 1 | Re-issue the load |
| res_recover_o | output | 1 | Branch to recovery code |
| nat_set_o | output | 1 | Mark a register as holding a deferred fault |
| nat_reg_o | output | REG_W | Register to be marked |

## Verification
The assertions assume that inputs are held steady around the clock edge and that the `*_valid_i` strobes are never X once reset is released. They place no limit on how the three ports may be combined in one cycle. Stimulus is applied on the falling edge and is zero whenever a port is idle. The same-cycle cases (insert with store, check with store, check with insert) are produced on purpose to exercise the ordering that R12 and R13 define. The table is filled past capacity only after a fresh reset, so that the position of the rotating pointer is known.

// File: rtl/alat_pkg.sv
package alat_pkg;
  localparam logic CHK_RELOAD = 1'b0;
  localparam logic CHK_BRANCH = 1'b1;
  localparam int unsigned GRAN_SHIFT = 3;
endpackage

// File: rtl/alat_conflict.sv
module alat_conflict #(
  parameter int unsigned GW = 29
) (
  input  logic [GW-1:0] a_gran_i,
  input  logic          a_wide_i,
  input  logic [GW-1:0] b_gran_i,
  input  logic          b_wide_i,
  output logic          hit_o
);
  logic pair_eq;
  logic low_eq;

  assign pair_eq = (a_gran_i[GW-1:1] == b_gran_i[GW-1:1]);
  assign low_eq  = (a_gran_i[0] == b_gran_i[0]);

  always_comb begin
    if (a_wide_i || b_wide_i) hit_o = pair_eq;
    else                      hit_o = pair_eq && low_eq;
  end
endmodule

// File: rtl/alat_victim.sv
module alat_victim #(
  parameter int unsigned ENTRIES = 32,
  localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [ENTRIES-1:0] reg_hit_i,
  input  logic               alloc_i,
  output logic [IDX_W-1:0]   slot_o,
  output logic               evict_o
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] rr_d;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] free_idx;
  logic             any_hit;
  logic             any_free;
  logic             rr_en;

  always_comb begin
    hit_idx = '0;
    any_hit = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!any_hit && reg_hit_i[i]) begin
        hit_idx = IDX_W'(i);
        any_hit = 1'b1;
      end
    end
  end

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!any_free && !valid_i[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  always_comb begin
    evict_o = !any_hit && !any_free;
    if (any_hit)       slot_o = hit_idx;
    else if (any_free) slot_o = free_idx;
    else               slot_o = rr_q;
  end

  assign rr_en = alloc_i && evict_o;

  always_comb begin
    rr_d = rr_q;
    if (rr_en) begin
      if (rr_q == IDX_W'(ENTRIES - 1)) rr_d = '0;
      else                             rr_d = rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end

  assert_victim_free_R11: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i && !(|reg_hit_i) && !(&valid_i) |-> !valid_i[slot_o]);

  assert_reuse_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i && (|reg_hit_i) |-> reg_hit_i[slot_o]);
endmodule

// File: rtl/alat_table.sv
module alat_table #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned REG_W   = 7,
  parameter int unsigned ADDR_W  = 32,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned GW     = ADDR_W - alat_pkg::GRAN_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid_i,
  input  logic [REG_W-1:0]  ins_reg_i,
  input  logic [ADDR_W-1:0] ins_addr_i,
  input  logic              ins_wide_i,
  input  logic              ins_defer_i,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic              st_wide_i,
  input  logic              chk_valid_i,
  input  logic [REG_W-1:0]  chk_reg_i,
  input  logic              chk_mode_i,
  input  logic              chk_clear_i,
  output logic              res_valid_o,
  output logic              res_hit_o,
  output logic              res_reload_o,
  output logic              res_recover_o,
  output logic              nat_set_o,
  output logic [REG_W-1:0]  nat_reg_o
);
  import alat_pkg::*;

  logic [1:0]         rst_q;
  logic               rst_core_n;

  logic [ENTRIES-1:0] tbl_valid;
  logic [ENTRIES-1:0] valid_d;
  logic [REG_W-1:0]   tbl_reg  [ENTRIES];
  logic [GW-1:0]      tbl_gran [ENTRIES];
  logic [ENTRIES-1:0] tbl_wide;

  logic [ENTRIES-1:0] ins_vec;
  logic [ENTRIES-1:0] chk_vec;
  logic [ENTRIES-1:0] cf_raw;
  logic [ENTRIES-1:0] st_conf;
  logic [GW-1:0]      ins_gran;
  logic [GW-1:0]      st_gran;
  logic               ins_we;
  logic [IDX_W-1:0]   slot;
  logic               evict;
  logic               chk_any;
  logic               unused_low;

  logic               res_valid_d, res_hit_d, res_reload_d, res_recover_d;
  logic               nat_set_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_core_n = rst_q[1];

  assign ins_gran   = ins_addr_i[ADDR_W-1:GRAN_SHIFT];
  assign st_gran    = st_addr_i[ADDR_W-1:GRAN_SHIFT];
  assign unused_low = ^{ins_addr_i[GRAN_SHIFT-1:0], st_addr_i[GRAN_SHIFT-1:0], evict};
  assign ins_we     = ins_valid_i && !ins_defer_i;
  assign chk_any    = |chk_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign ins_vec[g] = tbl_valid[g] && (tbl_reg[g] == ins_reg_i);
    assign chk_vec[g] = tbl_valid[g] && (tbl_reg[g] == chk_reg_i);

    alat_conflict #(.GW(GW)) u_conflict (
      .a_gran_i (tbl_gran[g]),
      .a_wide_i (tbl_wide[g]),
      .b_gran_i (st_gran),
      .b_wide_i (st_wide_i),
      .hit_o    (cf_raw[g])
    );
    assign st_conf[g] = st_valid_i && tbl_valid[g] && cf_raw[g];

    assert_store_kill_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
      st_conf[g] && !(ins_we && slot == IDX_W'(g)) |=> !tbl_valid[g]);

    assert_clear_kill_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
      chk_valid_i && chk_clear_i && chk_vec[g] && !(ins_we && slot == IDX_W'(g))
      |=> !tbl_valid[g]);

    assert_defer_kill_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
      ins_valid_i && ins_defer_i && ins_vec[g] |=> !tbl_valid[g]);
  end

  alat_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .valid_i   (tbl_valid),
    .reg_hit_i (ins_vec),
    .alloc_i   (ins_we),
    .slot_o    (slot),
    .evict_o   (evict)
  );

  // Older store first, then the clear, then the newest insert.
  always_comb begin
    valid_d = tbl_valid & ~st_conf;
    if (chk_valid_i && chk_clear_i) valid_d = valid_d & ~chk_vec;
    if (ins_valid_i && ins_defer_i) valid_d = valid_d & ~ins_vec;
    if (ins_we)                     valid_d[slot] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) tbl_valid <= '0;
    else             tbl_valid <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (ins_we) begin
      tbl_reg[slot]  <= ins_reg_i;
      tbl_gran[slot] <= ins_gran;
      tbl_wide[slot] <= ins_wide_i;
    end
  end

  always_comb begin
    res_valid_d   = chk_valid_i;
    res_hit_d     = chk_valid_i && chk_any;
    res_reload_d  = chk_valid_i && !chk_any && (chk_mode_i == CHK_RELOAD);
    res_recover_d = chk_valid_i && !chk_any && (chk_mode_i == CHK_BRANCH);
    nat_set_d     = ins_valid_i && ins_defer_i;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      res_valid_o   <= 1'b0;
      res_hit_o     <= 1'b0;
      res_reload_o  <= 1'b0;
      res_recover_o <= 1'b0;
      nat_set_o     <= 1'b0;
    end else begin
      res_valid_o   <= res_valid_d;
      res_hit_o     <= res_hit_d;
      res_reload_o  <= res_reload_d;
      res_recover_o <= res_recover_d;
      nat_set_o     <= nat_set_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)    nat_reg_o <= '0;
    else if (nat_set_d) nat_reg_o <= ins_reg_i;
  end

  assert_unique_reg_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0(chk_vec) && $onehot0(ins_vec));

  assert_hit_clean_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    res_hit_o |-> !res_reload_o && !res_recover_o);

  assert_miss_excl_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(res_reload_o && res_recover_o));

  assert_miss_flag_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    res_valid_o && !res_hit_o |-> $countones({res_reload_o, res_recover_o}) == 1);

  assert_new_entry_R12: assert property (@(posedge clk) disable iff (!rst_core_n)
    ins_we |=> tbl_valid[$past(slot)]);
endmodule

// File: tb/alat_table_test.sv
module alat_table_test;
  localparam int ENT = 32;
  localparam int RW  = 7;
  localparam int AW  = 32;
  localparam int GW  = AW - 3;

  typedef struct {
    bit    hit;
    bit    reload;
    bit    recover;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic ins_valid_i, ins_wide_i, ins_defer_i, st_valid_i, st_wide_i;
  logic chk_valid_i, chk_mode_i, chk_clear_i;
  logic [RW-1:0] ins_reg_i, chk_reg_i, nat_reg_o;
  logic [AW-1:0] ins_addr_i, st_addr_i;
  logic res_valid_o, res_hit_o, res_reload_o, res_recover_o, nat_set_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  exp_t exp_q[$];
  logic [RW-1:0] nat_q[$];

  bit          mv [ENT];
  logic [RW-1:0] mr [ENT];
  logic [GW-1:0] mg [ENT];
  bit          mw [ENT];
  int          mrr;

  bit s_iv, s_iw, s_idf, s_sv, s_sw, s_cv, s_cm, s_cc;
  logic [RW-1:0] s_ir, s_cr;
  logic [AW-1:0] s_ia, s_sa;
  string s_tag;

  always #4 clk = ~clk;

  alat_table uut (
    .clk(clk), .rst_n(rst_n),
    .ins_valid_i(ins_valid_i), .ins_reg_i(ins_reg_i), .ins_addr_i(ins_addr_i),
    .ins_wide_i(ins_wide_i), .ins_defer_i(ins_defer_i),
    .st_valid_i(st_valid_i), .st_addr_i(st_addr_i), .st_wide_i(st_wide_i),
    .chk_valid_i(chk_valid_i), .chk_reg_i(chk_reg_i), .chk_mode_i(chk_mode_i),
    .chk_clear_i(chk_clear_i),
    .res_valid_o(res_valid_o), .res_hit_o(res_hit_o), .res_reload_o(res_reload_o),
    .res_recover_o(res_recover_o), .nat_set_o(nat_set_o), .nat_reg_o(nat_reg_o)
  );

  function automatic bit overlap(logic [GW-1:0] g1, bit w1, logic [GW-1:0] g2, bit w2);
    if (w1 || w2) return g1[GW-1:1] == g2[GW-1:1];
    return g1 == g2;
  endfunction

  task automatic stage_clear();
    s_iv = 0; s_iw = 0; s_idf = 0; s_sv = 0; s_sw = 0; s_cv = 0; s_cm = 0; s_cc = 0;
    s_ir = '0; s_cr = '0; s_ia = '0; s_sa = '0; s_tag = "";
  endtask

  // Drive one cycle of staged stimulus and advance the reference table.
  task automatic step();
    exp_t e;
    bit chit, ihit, ifree;
    int islot;
    bit kill [ENT];
    @(negedge clk);
    ins_valid_i = s_iv; ins_reg_i = s_ir; ins_addr_i = s_ia; ins_wide_i = s_iw;
    ins_defer_i = s_idf; st_valid_i = s_sv; st_addr_i = s_sa; st_wide_i = s_sw;
    chk_valid_i = s_cv; chk_reg_i = s_cr; chk_mode_i = s_cm; chk_clear_i = s_cc;
    chit = 0;
    for (int j = 0; j < ENT; j++) if (mv[j] && mr[j] == s_cr) chit = 1;
    if (s_cv) begin
      e.hit = chit; e.reload = !chit && !s_cm; e.recover = !chit && s_cm; e.tag = s_tag;
      exp_q.push_back(e);
    end
    if (s_iv && s_idf) nat_q.push_back(s_ir);
    ihit = 0; ifree = 0; islot = mrr;
    for (int j = 0; j < ENT; j++) if (!ihit && mv[j] && mr[j] == s_ir) begin ihit = 1; islot = j; end
    if (!ihit) for (int j = 0; j < ENT; j++) if (!ifree && !mv[j]) begin ifree = 1; islot = j; end
    for (int j = 0; j < ENT; j++) begin
      kill[j] = 0;
      if (s_sv && mv[j] && overlap(mg[j], mw[j], s_sa[AW-1:3], s_sw)) kill[j] = 1;
      if (s_cv && s_cc && mv[j] && mr[j] == s_cr) kill[j] = 1;
      if (s_iv && s_idf && mv[j] && mr[j] == s_ir) kill[j] = 1;
    end
    for (int j = 0; j < ENT; j++) if (kill[j]) mv[j] = 0;
    if (s_iv && !s_idf) begin
      mv[islot] = 1; mr[islot] = s_ir; mg[islot] = s_ia[AW-1:3]; mw[islot] = s_iw;
      if (!ihit && !ifree) mrr = (mrr + 1) % ENT;
    end
    stage_clear();
  endtask

  task automatic ins(input logic [RW-1:0] r, input logic [AW-1:0] a, input bit w = 0, input bit df = 0);
    s_iv = 1; s_ir = r; s_ia = a; s_iw = w; s_idf = df; step();
  endtask

  task automatic st(input logic [AW-1:0] a, input bit w = 0);
    s_sv = 1; s_sa = a; s_sw = w; step();
  endtask

  task automatic chk(input logic [RW-1:0] r, input bit m, input bit c, input string tag);
    s_cv = 1; s_cr = r; s_cm = m; s_cc = c; s_tag = tag; step();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic check_bit(input string tag, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, expv);
    end
  endtask

  task automatic do_reset();
    idle(2);
    @(negedge clk);
    rst_n = 0;
    for (int j = 0; j < ENT; j++) mv[j] = 0;
    mrr = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && res_valid_o) begin
      exp_t e;
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL unexpected result hit=%0b expected no result", res_hit_o);
      end else begin
        e = exp_q.pop_front();
        if (res_hit_o !== e.hit || res_reload_o !== e.reload || res_recover_o !== e.recover) begin
          failures++;
          $display("FAIL %s actual hit/reload/recover=%0b%0b%0b expected=%0b%0b%0b",
                   e.tag, res_hit_o, res_reload_o, res_recover_o, e.hit, e.reload, e.recover);
        end
      end
    end
    if (rst_n && nat_set_o) begin
      checks++;
      if (nat_q.size() == 0) begin
        failures++;
        $display("FAIL R10 unexpected nat_set reg=%0d expected none", nat_reg_o);
      end else begin
        logic [RW-1:0] er;
        er = nat_q.pop_front();
        if (nat_reg_o !== er) begin
          failures++;
          $display("FAIL R10 nat_reg actual=%0d expected=%0d", nat_reg_o, er);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    stage_clear();
    rst_n = 0;
    ins_valid_i = 0; ins_reg_i = 0; ins_addr_i = 0; ins_wide_i = 0; ins_defer_i = 0;
    st_valid_i = 0; st_addr_i = 0; st_wide_i = 0;
    chk_valid_i = 0; chk_reg_i = 0; chk_mode_i = 0; chk_clear_i = 0;
    for (int j = 0; j < ENT; j++) mv[j] = 0;
    mrr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check_bit("R1 res_valid", res_valid_o, 1'b0);
    check_bit("R1 res_hit", res_hit_o, 1'b0);
    check_bit("R1 res_reload", res_reload_o, 1'b0);
    check_bit("R1 res_recover", res_recover_o, 1'b0);
    check_bit("R1 nat_set", nat_set_o, 1'b0);
    chk(7'd5, 1, 0, "R1 empty miss");

    // R2 R3 R4 R5
    ins(7'd10, 32'h1000);
    chk(7'd10, 0, 0, "R2 R3 hit reload form");
    chk(7'd10, 1, 0, "R3 hit branch form");
    chk(7'd11, 0, 0, "R4 miss reload");
    chk(7'd11, 1, 0, "R5 miss recover");

    // R6 granule
    st(32'h1004);
    chk(7'd10, 0, 0, "R6 same granule kills");
    ins(7'd12, 32'h2000);
    st(32'h2008);
    chk(7'd12, 1, 0, "R6 next granule keeps");

    // R7 wide
    ins(7'd13, 32'h3000);
    st(32'h3008, 1);
    chk(7'd13, 1, 0, "R7 wide store kills pair");
    ins(7'd14, 32'h4008, 1);
    st(32'h4000);
    chk(7'd14, 1, 0, "R7 wide entry killed");
    ins(7'd15, 32'h5000);
    st(32'h5010, 1);
    chk(7'd15, 1, 0, "R7 other pair keeps");

    // R8 clear
    ins(7'd20, 32'h6000);
    chk(7'd20, 1, 1, "R8 clear check hits");
    chk(7'd20, 1, 0, "R8 after clear miss");
    ins(7'd21, 32'h6100);
    chk(7'd21, 0, 0, "R8 no clear hit");
    chk(7'd21, 0, 0, "R8 no clear still hit");

    // R9 overwrite
    ins(7'd22, 32'h7000);
    ins(7'd22, 32'h8000);
    st(32'h7000);
    chk(7'd22, 0, 0, "R9 old address ignored");
    st(32'h8000);
    chk(7'd22, 0, 0, "R9 new address kills");

    // R10 defer
    ins(7'd23, 32'h9000);
    ins(7'd23, 32'h9100, 0, 1);
    chk(7'd23, 0, 0, "R10 deferred no entry");
    ins(7'd24, 32'h9200, 0, 1);
    chk(7'd24, 1, 0, "R10 deferred fresh miss");

    // R12 insert with same-cycle store
    s_iv = 1; s_ir = 7'd25; s_ia = 32'hA000; s_sv = 1; s_sa = 32'hA000; step();
    chk(7'd25, 0, 0, "R12 insert survives store");

    // R13 check ordering
    ins(7'd26, 32'hB000);
    s_cv = 1; s_cr = 7'd26; s_cm = 1; s_sv = 1; s_sa = 32'hB000; s_tag = "R13 store same cycle"; step();
    chk(7'd26, 1, 0, "R13 store then applied");
    s_cv = 1; s_cr = 7'd27; s_cm = 0; s_iv = 1; s_ir = 7'd27; s_ia = 32'hC000; s_tag = "R13 insert same cycle"; step();
    chk(7'd27, 0, 0, "R13 insert then visible");

    // R11 full table replacement
    do_reset();
    check_bit("R1 after reset valid", res_valid_o, 1'b0);
    for (int i = 0; i < ENT; i++) ins(RW'(i), 32'h10000 + 32'(i) * 64);
    ins(7'd100, 32'h20000);
    chk(7'd0, 0, 0, "R11 slot0 replaced");
    chk(7'd1, 0, 0, "R11 slot1 kept");
    chk(7'd100, 0, 0, "R11 newcomer hit");
    ins(7'd101, 32'h20100);
    chk(7'd1, 1, 0, "R11 slot1 replaced next");
    chk(7'd2, 1, 0, "R11 slot2 kept");
    st(32'h10000 + 5 * 64);
    ins(7'd102, 32'h20200);
    ins(7'd103, 32'h20300);
    chk(7'd102, 0, 0, "R11 freed slot reused");
    chk(7'd2, 0, 0, "R11 pointer slot2 replaced");
    chk(7'd3, 0, 0, "R11 slot3 kept");
    idle(3);

    checks++;
    if (exp_q.size() != 0 || nat_q.size() != 0) begin
      failures++;
      $display("FAIL R2 pending results actual=%0d expected=0", exp_q.size() + nat_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule